// File: doc/BRIEF.md
# Extended-Precision Compare and Classify Condition Unit

This unit turns one or two floating-point operands in the 80-bit extended format into the condition information that a floating-point stack machine reports. The first operand is the top of the register stack. The second operand is either a register or a converted memory value, and a zero constant replaces it in test mode. A two-bit mode input selects what is reported. Compare and test modes report the status-word condition bits. Flag mode reports the integer zero, carry and parity flags. Examine mode classifies the top operand and uses an input that says whether its stack slot is empty. An invalid indication goes with any comparison that meets a NaN.

An operand is laid out as `{sign, exponent[EXP_W-1:0], significand[SIG_W-1:0]}`. The significand's top bit is the explicit integer bit. The defaults, EXP_W=15 and SIG_W=64, give the 80-bit format. The decode is combinational and its result is registered once. Every output therefore shows the inputs of the previous rising clock edge. The result of one operation is consumed by the stage that follows.

Top module: `fpcc_unit`

## Requirements
- R1: Every output is registered, so the outputs in a cycle reflect the inputs sampled at the previous rising edge. While rst_n is low, all outputs are zero.
- R2: In compare mode (mode=00), C1 (cc[1]) is 0. For an ordered pair, C0 (cc[0]) is x<y, C3 (cc[3]) is x==y and C2 (cc[2]) is 0. In this case invalid, zf, cf and pf are all 0.
- R3: A pair is unordered when either operand is a NaN, meaning its exponent is all ones and its fraction (the significand without the integer bit) is nonzero. For an unordered pair in compare mode, cc=4'b1101 and invalid is 1.
- R4: The ordering works as follows. Plus zero and minus zero are equal. When the signs differ, the negative operand is the smaller. When both operands are positive, the larger {exponent, significand} field is the larger value. When both are negative, that order is reversed.
- R5: In flag mode (mode=01), an ordered pair gives zf = x==y, cf = x<y and pf = 0. The outputs cc and invalid are 0.
- R6: In flag mode, an unordered pair sets zf, cf and pf all to 1 and sets invalid to 1.
- R7: In test mode (mode=11), the result equals a compare-mode result with the second operand replaced by +0. The src input has no effect in this mode.
- R8: In examine mode (mode=10), C1 is the sign of st0. An empty slot gives {C3,C2,C0}=3'b101. Examine mode never raises invalid, and it leaves zf, cf and pf at 0.
- R9: For a non-empty st0, {C3,C2,C0} reports the class as follows: NaN 3'b001, infinity 3'b011, zero 3'b100, subnormal 3'b110 and normal 3'b010.
- R10: The class is taken from the fields.
  - An all-ones exponent with a zero fraction is infinity. The integer bit is ignored here, and a nonzero fraction is NaN.
  - A zero exponent with an all-zero significand is zero. A zero exponent with any other significand is subnormal.
  - Every other encoding is normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 compare, 01 flags, 10 examine, 11 test against +0 |
| st0 | input | 1+EXP_W+SIG_W | Top-of-stack operand (x) |
| src | input | 1+EXP_W+SIG_W | Second operand (y) |
| st0_empty | input | 1 | Slot of st0 is tagged empty (examine mode) |
| cc | output | 4 | Condition bits C3..C0 at positions 3..0 |
| zf | output | 1 | Zero flag (flag mode) |
| cf | output | 1 | Carry flag (flag mode) |
| pf | output | 1 | Parity flag (flag mode) |
| invalid | output | 1 | Invalid-operation indication |

## Verification
The bench builds the unit with EXP_W=3 and SIG_W=3, which gives 7-bit operands. With these values every operand pair can be swept in compare mode and again in flag mode, 16384 pairs each. The sweep covers every sign combination, both zeros, NaNs with and without the integer bit, and encodings that are not canonical. Every operand is also classified with its slot both empty and full. Test mode runs over every st0 value, with src driven to random values that include NaNs, to show that src is ignored.

// File: rtl/fpcc_pkg.sv
`timescale 1ns/1ps
package fpcc_pkg;

    typedef enum logic [1:0] {
        MODE_CMP  = 2'b00,
        MODE_FLAG = 2'b01,
        MODE_EXAM = 2'b10,
        MODE_TEST = 2'b11
    } fpcc_mode_e;

    typedef enum logic [2:0] {
        CLS_NAN  = 3'd0,
        CLS_INF  = 3'd1,
        CLS_ZERO = 3'd2,
        CLS_SUB  = 3'd3,
        CLS_NORM = 3'd4
    } fpcc_class_e;

    typedef struct packed {
        logic [3:0] cc;
        logic       zf;
        logic       cf;
        logic       pf;
        logic       inv;
    } fpcc_out_t;

endpackage

// File: rtl/fpcc_classify.sv
`timescale 1ns/1ps
module fpcc_classify
    import fpcc_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int OP_W = 1 + EXP_W + SIG_W
) (
    input  logic [OP_W-1:0] op,
    output fpcc_class_e     cls
);
    logic [EXP_W-1:0] exp_f;
    logic [SIG_W-1:0] sig_f;
    logic [SIG_W-2:0] frac_f;

    assign exp_f  = op[OP_W-2:SIG_W];
    assign sig_f  = op[SIG_W-1:0];
    assign frac_f = op[SIG_W-2:0];

    always_comb begin
        if (&exp_f) begin
            cls = (frac_f == '0) ? CLS_INF : CLS_NAN;
        end else if (exp_f == '0) begin
            cls = (sig_f == '0) ? CLS_ZERO : CLS_SUB;
        end else begin
            cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/fpcc_order.sv
`timescale 1ns/1ps
module fpcc_order #(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int OP_W  = 1 + EXP_W + SIG_W,
    localparam int MAG_W = EXP_W + SIG_W
) (
    input  logic [OP_W-1:0] a,
    input  logic [OP_W-1:0] b,
    output logic            lt,
    output logic            eq
);
    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;
    logic             sgn_a;
    logic             sgn_b;
    logic             both_zero;

    assign mag_a     = a[MAG_W-1:0];
    assign mag_b     = b[MAG_W-1:0];
    assign sgn_a     = a[OP_W-1];
    assign sgn_b     = b[OP_W-1];
    assign both_zero = (mag_a == '0) && (mag_b == '0);

    always_comb begin
        eq = both_zero || (a == b);
        if (both_zero) begin
            lt = 1'b0;
        end else if (sgn_a != sgn_b) begin
            lt = sgn_a;
        end else if (!sgn_a) begin
            lt = (mag_a < mag_b);
        end else begin
            lt = (mag_a > mag_b);
        end
    end
endmodule

// File: rtl/fpcc_unit.sv
`timescale 1ns/1ps
module fpcc_unit
    import fpcc_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int OP_W = 1 + EXP_W + SIG_W,
    localparam int N_OPND = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic [OP_W-1:0] st0,
    input  logic [OP_W-1:0] src,
    input  logic            st0_empty,
    output logic [3:0]      cc,
    output logic            zf,
    output logic            cf,
    output logic            pf,
    output logic            invalid
);
    fpcc_mode_e      mode_e;
    logic [OP_W-1:0] opnd [N_OPND];
    fpcc_class_e     cls  [N_OPND];
    logic            x_lt_y;
    logic            x_eq_y;
    logic            unord;
    fpcc_out_t       out_d;
    fpcc_out_t       out_q;

    assign mode_e  = fpcc_mode_e'(mode);
    assign opnd[0] = st0;
    assign opnd[1] = (mode_e == MODE_TEST) ? '0 : src;

    for (genvar g = 0; g < N_OPND; g++) begin : g_cls
        fpcc_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
            .op  (opnd[g]),
            .cls (cls[g])
        );
    end

    fpcc_order #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_order (
        .a  (opnd[0]),
        .b  (opnd[1]),
        .lt (x_lt_y),
        .eq (x_eq_y)
    );

    assign unord = (cls[0] == CLS_NAN) || (cls[1] == CLS_NAN);

    always_comb begin
        out_d = '0;
        unique case (mode_e)
            MODE_CMP, MODE_TEST: begin
                if (unord) begin
                    out_d.cc  = 4'b1101;
                    out_d.inv = 1'b1;
                end else begin
                    out_d.cc = {x_eq_y, 1'b0, 1'b0, x_lt_y};
                end
            end
            MODE_FLAG: begin
                if (unord) begin
                    out_d.zf  = 1'b1;
                    out_d.cf  = 1'b1;
                    out_d.pf  = 1'b1;
                    out_d.inv = 1'b1;
                end else begin
                    out_d.zf = x_eq_y;
                    out_d.cf = x_lt_y;
                end
            end
            MODE_EXAM: begin
                out_d.cc[1] = st0[OP_W-1];
                if (st0_empty) begin
                    {out_d.cc[3], out_d.cc[2], out_d.cc[0]} = 3'b101;
                end else begin
                    unique case (cls[0])
                        CLS_NAN:  {out_d.cc[3], out_d.cc[2], out_d.cc[0]} = 3'b001;
                        CLS_INF:  {out_d.cc[3], out_d.cc[2], out_d.cc[0]} = 3'b011;
                        CLS_ZERO: {out_d.cc[3], out_d.cc[2], out_d.cc[0]} = 3'b100;
                        CLS_SUB:  {out_d.cc[3], out_d.cc[2], out_d.cc[0]} = 3'b110;
                        default:  {out_d.cc[3], out_d.cc[2], out_d.cc[0]} = 3'b010;
                    endcase
                end
            end
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cc      = out_q.cc;
    assign zf      = out_q.zf;
    assign cf      = out_q.cf;
    assign pf      = out_q.pf;
    assign invalid = out_q.inv;
endmodule

// File: rtl/fpcc_checks.sv
`timescale 1ns/1ps
module fpcc_checks
    import fpcc_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int OP_W = 1 + EXP_W + SIG_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      mode,
    input logic [OP_W-1:0] st0,
    input logic [OP_W-1:0] src,
    input logic            st0_empty,
    input logic [3:0]      cc,
    input logic            zf,
    input logic            cf,
    input logic            pf,
    input logic            invalid
);
    logic seen_q;
    logic st0_nan;
    logic src_nan;
    logic st0_mag0;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assign st0_nan  = (&st0[OP_W-2:SIG_W]) && (st0[SIG_W-2:0] != '0);
    assign src_nan  = (&src[OP_W-2:SIG_W]) && (src[SIG_W-2:0] != '0);
    assign st0_mag0 = (st0[OP_W-2:0] == '0);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (cc == 4'b0 && !zf && !cf && !pf && !invalid));

    // R2
    a_r2_cmp_c1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(mode) == MODE_CMP) |-> !cc[1]);

    // R2
    a_r2_cmp_ordered_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(mode) == MODE_CMP && !invalid) |-> (!cc[2] && !(cc[3] && cc[0]) && !zf && !cf && !pf));

    // R3
    a_r3_cmp_unordered: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(mode) == MODE_CMP && $past(st0_nan || src_nan)) |-> (cc == 4'b1101 && invalid));

    // R5
    a_r5_flag_ordered: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(mode) == MODE_FLAG && !pf) |-> (!(zf && cf) && cc == 4'b0 && !invalid));

    // R6
    a_r6_flag_unordered: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(mode) == MODE_FLAG && $past(st0_nan || src_nan)) |-> (zf && cf && pf && invalid));

    // R7
    a_r7_test_zero_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(mode) == MODE_TEST && $past(st0_mag0)) |-> (cc == 4'b1000 && !invalid));

    // R8
    a_r8_exam_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(mode) == MODE_EXAM && $past(st0_empty)) |->
        (cc[3] && !cc[2] && cc[0] && cc[1] == $past(st0[OP_W-1]) && !invalid && !zf && !cf && !pf));

    // R9
    a_r9_exam_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(mode) == MODE_EXAM && !$past(st0_empty)) |->
        ({cc[3], cc[2], cc[0]} != 3'b111 && {cc[3], cc[2], cc[0]} != 3'b101 && {cc[3], cc[2], cc[0]} != 3'b000 && !invalid));
endmodule

bind fpcc_unit fpcc_checks #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .st0       (st0),
    .src       (src),
    .st0_empty (st0_empty),
    .cc        (cc),
    .zf        (zf),
    .cf        (cf),
    .pf        (pf),
    .invalid   (invalid)
);

// File: tb/sim_fpcc_unit.sv
`timescale 1ns/1ps
module sim_fpcc_unit;
    localparam int E    = 3;
    localparam int S    = 3;
    localparam int W    = 1 + E + S;
    localparam int NVAL = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] st0 = '0;
    logic [W-1:0] src = '0;
    logic         st0_empty = 1'b0;
    logic [3:0]   cc;
    logic         zf, cf, pf, invalid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    fpcc_unit #(.EXP_W(E), .SIG_W(S)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .st0(st0), .src(src),
        .st0_empty(st0_empty), .cc(cc), .zf(zf), .cf(cf), .pf(pf), .invalid(invalid)
    );

    function automatic int key_of(logic [W-1:0] v);
        int m;
        m = int'(v[W-2:0]);
        return v[W-1] ? -m : m;
    endfunction

    function automatic bit nan_of(logic [W-1:0] v);
        return (v[W-2:S] == {E{1'b1}}) && (v[S-2:0] != '0);
    endfunction

    function automatic logic [7:0] cmp_exp(logic [W-1:0] x, logic [W-1:0] y);
        if (nan_of(x) || nan_of(y)) return {4'b1101, 3'b000, 1'b1};
        return {(key_of(x) == key_of(y)), 2'b00, (key_of(x) < key_of(y)), 4'b0000};
    endfunction

    function automatic logic [7:0] flag_exp(logic [W-1:0] x, logic [W-1:0] y);
        if (nan_of(x) || nan_of(y)) return {4'b0000, 4'b1111};
        return {4'b0000, (key_of(x) == key_of(y)), (key_of(x) < key_of(y)), 2'b00};
    endfunction

    function automatic logic [7:0] exam_exp(logic [W-1:0] x, bit empty);
        logic [2:0] c;
        if (empty)                        c = 3'b101;
        else if (x[W-2:S] == {E{1'b1}})   c = (x[S-2:0] == '0) ? 3'b011 : 3'b001;
        else if (x[W-2:S] == '0)          c = (x[S-1:0] == '0) ? 3'b100 : 3'b110;
        else                              c = 3'b010;
        return {c[2], c[1], x[W-1], c[0], 4'b0000};
    endfunction

    task automatic check(string req, logic [7:0] exp_v);
        logic [7:0] got;
        got = {cc, zf, cf, pf, invalid};
        n_cmp++;
        if (got !== exp_v) begin
            n_bad++;
            if (n_bad < 20)
                $display("FAIL %s mode=%b st0=%h src=%h empty=%b got=%b exp=%b",
                         req, mode, st0, src, st0_empty, got, exp_v);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog expired got=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] e;
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h00);
        mode = 2'b01; st0 = {1'b0, {E{1'b1}}, {S{1'b1}}}; src = '0;
        @(negedge clk);
        check("R1 reset holds", 8'h00);
        rst_n = 1'b1;

        // compare mode, every pair
        for (int x = 0; x < NVAL; x++) begin
            for (int y = 0; y < NVAL; y++) begin
                mode = 2'b00; st0 = W'(x); src = W'(y); st0_empty = x[0];
                e = cmp_exp(W'(x), W'(y));
                @(negedge clk);
                if (nan_of(st0) || nan_of(src))          check("R3", e);
                else if (st0[W-1] || src[W-1])           check("R4", e);
                else                                     check("R2", e);
            end
        end

        // flag mode, every pair
        for (int x = 0; x < NVAL; x++) begin
            for (int y = 0; y < NVAL; y++) begin
                mode = 2'b01; st0 = W'(x); src = W'(y);
                e = flag_exp(W'(x), W'(y));
                @(negedge clk);
                if (nan_of(st0) || nan_of(src)) check("R6", e);
                else                            check("R5", e);
            end
        end

        // test mode: src must not matter
        for (int x = 0; x < NVAL; x++) begin
            for (int k = 0; k < 4; k++) begin
                mode = 2'b11; st0 = W'(x); src = W'($urandom);
                e = cmp_exp(W'(x), '0);
                @(negedge clk);
                check("R7", e);
            end
        end

        // examine mode, every operand, empty and full
        for (int x = 0; x < NVAL; x++) begin
            for (int m = 0; m < 2; m++) begin
                mode = 2'b10; st0 = W'(x); src = W'($urandom); st0_empty = m[0];
                e = exam_exp(W'(x), m[0]);
                @(negedge clk);
                if (m == 1)                        check("R8", e);
                else if (st0[W-2:S] == {E{1'b1}})  check("R10", e);
                else                               check("R9", e);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule